// File: doc/BRIEF.md
# Dual-Side Configuration Access Gate

This block sits in a two-bus bridge and decides, for each bus, what happens to a configuration cycle that shows up in an address phase. It decodes a Type 0 configuration cycle from the command nibble, the two low address bits and the device-select line. One clock later it reports exactly one decision for that bus: accept, retry or ignore. The secondary side is never retried.

The gate holds a single configuration-busy control bit. Every reset loads it from a strap pin. While the bit is 1, any primary-side Type 0 configuration cycle that would otherwise be claimed is answered with a retry. This lets an agent on the secondary bus set up the bridge without contention from the primary bus. That agent then releases the primary side by writing 0 to the bit with a secondary-side configuration write. Writes reach the bit through a data phase that follows an accepted configuration write. The bit lives in the dword at byte offset 44h, bit 2, lane 0. When the strap and the secondary device-select are both tied low, the secondary side never claims anything and the primary side is never held off.

Top module: `cfg_access_gate`

## Requirements
- R1: One clock after a secondary address phase, `sec_accept_o` is 1 if and only if the command is 4'b1010 (config read) or 4'b1011 (config write), address bits [1:0] are 2'b00, and `sec_idsel_i` is 1. Otherwise `sec_ignore_o` is 1.
- R2: After a synchronous reset, `busy_o` equals the value of `busy_strap_i` during reset, and all decision outputs are 0.
- R3: While `busy_o` is 1, a primary address phase that meets the R1 conditions, with `pri_idsel_i` in place of `sec_idsel_i`, gives `pri_retry_o`=1 and `pri_accept_o`=0 one clock later.
- R4: While `busy_o` is 0, such a qualifying primary address phase gives `pri_accept_o`=1 one clock later.
- R5: A primary address phase that does not qualify gives `pri_ignore_o`=1, whatever the value of `busy_o`.
- R6: An accepted secondary config write to byte address 8'h44, followed by a data phase with lane 0 enabled (`wbe[0]`=1) and data bit 2 equal to 0, clears `busy_o`. Primary config cycles are accepted after that.
- R7: `busy_o` is unchanged by a data phase with `wbe[0]`=0, by a data phase for an accepted write to another register, and by a data phase that follows a config read.
- R8: Once `busy_o` is 0, an accepted primary config write to 8'h44 with data bit 2 equal to 1 and lane 0 enabled sets `busy_o` again.
- R9: For each bus, at most one of accept/retry/ignore is 1 in any cycle, and all are 0 in a cycle that does not follow an address phase on that bus.
- R10: With the strap low and `sec_idsel_i` held low, secondary config cycles are ignored and primary config cycles are never retried.
- R11: If both buses deliver a busy-bit data phase in the same cycle, the secondary value wins.
- R12: A data phase with no pending accepted write has no effect. Each accepted write consumes exactly one data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_strap_i | input | 1 | Strap loaded into the busy bit at reset |
| pri_addr_valid_i | input | 1 | Primary address phase strobe |
| pri_cmd_i | input | 4 | Primary command nibble |
| pri_addr_i | input | ADDR_W | Primary low address bits (register byte address) |
| pri_idsel_i | input | 1 | Primary device select |
| pri_wdata_valid_i | input | 1 | Primary write data phase strobe |
| pri_wdata_i | input | DATA_W | Primary write data |
| pri_wbe_i | input | DATA_W/8 | Primary byte enables, active high |
| sec_addr_valid_i | input | 1 | Secondary address phase strobe |
| sec_cmd_i | input | 4 | Secondary command nibble |
| sec_addr_i | input | ADDR_W | Secondary low address bits |
| sec_idsel_i | input | 1 | Secondary device select |
| sec_wdata_valid_i | input | 1 | Secondary write data phase strobe |
| sec_wdata_i | input | DATA_W | Secondary write data |
| sec_wbe_i | input | DATA_W/8 | Secondary byte enables, active high |
| pri_accept_o | output | 1 | Primary cycle claimed |
| pri_retry_o | output | 1 | Primary cycle to be retried |
| pri_ignore_o | output | 1 | Primary cycle not for this bridge |
| sec_accept_o | output | 1 | Secondary cycle claimed |
| sec_ignore_o | output | 1 | Secondary cycle not for this bridge |
| busy_o | output | 1 | Current configuration-busy bit |

## Verification
The decode is exercised on each side with the two config commands and with a memory command. It is also tried with addresses 8'h44, 8'h45 and 8'h46 and with the select line high and low, so that each of the three qualifying conditions is shown to be necessary on its own. Primary qualifying cycles are sent with the busy bit at 1, then at 0, then at 1 again. This separates retry from accept and shows that the bit, and not the strap, drives the hold-off. Writes to the bit vary the register, the lane enable, the command, the presence of a pending write and a simultaneous write from both buses. Together these show that only a genuine accepted write to lane 0 of 8'h44 reaches the bit, and that the secondary side wins a same-cycle write.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

  typedef struct packed {
    logic accept;
    logic retry;
    logic ignore;
  } gate_dec_t;
endpackage

// File: rtl/cfg_type0_decode.sv
module cfg_type0_decode
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_i,
  output logic              hit_o,
  output logic              is_write_o
);
  logic cmd_is_cfg;
  logic unused_addr;

  // only the type bits matter here; the register index is used elsewhere
  assign unused_addr = ^addr_i[ADDR_W-1:2];
  assign cmd_is_cfg  = (cmd_i == CMD_CFG_READ) || (cmd_i == CMD_CFG_WRITE);
  assign hit_o       = sel_i && (addr_i[1:0] == 2'b00) && cmd_is_cfg;
  assign is_write_o  = (cmd_i == CMD_CFG_WRITE);
endmodule

// File: rtl/cfg_side_port.sv
module cfg_side_port
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter bit HOLDOFF = 1'b0,
  localparam int IDX_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_i,
  input  logic              hold_i,
  input  logic              wdata_valid_i,
  output gate_dec_t         dec_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  wr_idx_o
);
  logic             hit;
  logic             is_write;
  logic             held;
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  gate_dec_t        dec_q;

  cfg_type0_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .sel_i      (sel_i),
    .hit_o      (hit),
    .is_write_o (is_write)
  );

  generate
    if (HOLDOFF) begin : g_hold
      assign held = hold_i;
    end else begin : g_nohold
      logic unused_hold;
      assign unused_hold = hold_i;
      assign held        = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= '0;
    end else begin
      dec_q.accept <= addr_valid_i && hit && !held;
      dec_q.retry  <= addr_valid_i && hit && held;
      dec_q.ignore <= addr_valid_i && !hit;
    end
  end

  // remember an accepted write until its data phase arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else if (addr_valid_i) begin
      pend_q     <= hit && !held && is_write;
      pend_idx_q <= addr_i[ADDR_W-1:2];
    end else if (wdata_valid_i) begin
      pend_q     <= 1'b0;
    end
  end

  assign dec_o    = dec_q;
  assign wr_stb_o = wdata_valid_i && pend_q;
  assign wr_idx_o = pend_idx_q;
endmodule

// File: rtl/cfg_busy_bit.sv
module cfg_busy_bit #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_IDX = 'h11,
  parameter int BUSY_BIT = 2,
  localparam int IDX_W   = ADDR_W - 2,
  localparam int BE_W    = DATA_W / 8,
  localparam int LANE    = BUSY_BIT / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              sec_stb_i,
  input  logic [IDX_W-1:0]  sec_idx_i,
  input  logic [DATA_W-1:0] sec_data_i,
  input  logic [BE_W-1:0]   sec_be_i,
  input  logic              pri_stb_i,
  input  logic [IDX_W-1:0]  pri_idx_i,
  input  logic [DATA_W-1:0] pri_data_i,
  input  logic [BE_W-1:0]   pri_be_i,
  output logic              busy_o
);
  logic busy_q;
  logic sec_hit;
  logic pri_hit;
  logic unused_bits;

  assign unused_bits = ^{sec_data_i, sec_be_i, pri_data_i, pri_be_i};

  assign sec_hit = sec_stb_i && (sec_idx_i == IDX_W'(BUSY_IDX)) && sec_be_i[LANE];
  assign pri_hit = pri_stb_i && (pri_idx_i == IDX_W'(BUSY_IDX)) && pri_be_i[LANE];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= strap_i;
    end else if (sec_hit) begin
      busy_q <= sec_data_i[BUSY_BIT];
    end else if (pri_hit) begin
      busy_q <= pri_data_i[BUSY_BIT];
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_IDX = 'h11,
  parameter int BUSY_BIT = 2,
  localparam int IDX_W   = ADDR_W - 2,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_strap_i,
  input  logic              pri_addr_valid_i,
  input  logic [3:0]        pri_cmd_i,
  input  logic [ADDR_W-1:0] pri_addr_i,
  input  logic              pri_idsel_i,
  input  logic              pri_wdata_valid_i,
  input  logic [DATA_W-1:0] pri_wdata_i,
  input  logic [BE_W-1:0]   pri_wbe_i,
  input  logic              sec_addr_valid_i,
  input  logic [3:0]        sec_cmd_i,
  input  logic [ADDR_W-1:0] sec_addr_i,
  input  logic              sec_idsel_i,
  input  logic              sec_wdata_valid_i,
  input  logic [DATA_W-1:0] sec_wdata_i,
  input  logic [BE_W-1:0]   sec_wbe_i,
  output logic              pri_accept_o,
  output logic              pri_retry_o,
  output logic              pri_ignore_o,
  output logic              sec_accept_o,
  output logic              sec_ignore_o,
  output logic              busy_o
);
  gate_dec_t        pri_dec;
  gate_dec_t        sec_dec;
  logic             pri_stb;
  logic             sec_stb;
  logic [IDX_W-1:0] pri_idx;
  logic [IDX_W-1:0] sec_idx;
  logic             busy;
  logic             unused_sec_retry;

  cfg_side_port #(.ADDR_W(ADDR_W), .HOLDOFF(1'b1)) u_pri (
    .clk           (clk),
    .rst           (rst),
    .addr_valid_i  (pri_addr_valid_i),
    .cmd_i         (pri_cmd_i),
    .addr_i        (pri_addr_i),
    .sel_i         (pri_idsel_i),
    .hold_i        (busy),
    .wdata_valid_i (pri_wdata_valid_i),
    .dec_o         (pri_dec),
    .wr_stb_o      (pri_stb),
    .wr_idx_o      (pri_idx)
  );

  cfg_side_port #(.ADDR_W(ADDR_W), .HOLDOFF(1'b0)) u_sec (
    .clk           (clk),
    .rst           (rst),
    .addr_valid_i  (sec_addr_valid_i),
    .cmd_i         (sec_cmd_i),
    .addr_i        (sec_addr_i),
    .sel_i         (sec_idsel_i),
    .hold_i        (1'b0),
    .wdata_valid_i (sec_wdata_valid_i),
    .dec_o         (sec_dec),
    .wr_stb_o      (sec_stb),
    .wr_idx_o      (sec_idx)
  );

  cfg_busy_bit #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUSY_IDX (BUSY_IDX),
    .BUSY_BIT (BUSY_BIT)
  ) u_busy (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (busy_strap_i),
    .sec_stb_i  (sec_stb),
    .sec_idx_i  (sec_idx),
    .sec_data_i (sec_wdata_i),
    .sec_be_i   (sec_wbe_i),
    .pri_stb_i  (pri_stb),
    .pri_idx_i  (pri_idx),
    .pri_data_i (pri_wdata_i),
    .pri_be_i   (pri_wbe_i),
    .busy_o     (busy)
  );

  assign unused_sec_retry = sec_dec.retry;
  assign pri_accept_o = pri_dec.accept;
  assign pri_retry_o  = pri_dec.retry;
  assign pri_ignore_o = pri_dec.ignore;
  assign sec_accept_o = sec_dec.accept;
  assign sec_ignore_o = sec_dec.ignore;
  assign busy_o       = busy;
endmodule

// File: rtl/cfg_access_gate_chk.sv
module cfg_access_gate_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_strap_i,
  input logic              pri_addr_valid_i,
  input logic [3:0]        pri_cmd_i,
  input logic [ADDR_W-1:0] pri_addr_i,
  input logic              pri_idsel_i,
  input logic              pri_wdata_valid_i,
  input logic              sec_addr_valid_i,
  input logic [3:0]        sec_cmd_i,
  input logic [ADDR_W-1:0] sec_addr_i,
  input logic              sec_idsel_i,
  input logic              sec_wdata_valid_i,
  input logic              pri_accept_o,
  input logic              pri_retry_o,
  input logic              pri_ignore_o,
  input logic              sec_accept_o,
  input logic              sec_ignore_o,
  input logic              busy_o
);
  logic pri_qual;
  logic sec_qual;

  assign pri_qual = pri_addr_valid_i && pri_idsel_i && (pri_addr_i[1:0] == 2'b00) &&
                    ((pri_cmd_i == 4'b1010) || (pri_cmd_i == 4'b1011));
  assign sec_qual = sec_addr_valid_i && sec_idsel_i && (sec_addr_i[1:0] == 2'b00) &&
                    ((sec_cmd_i == 4'b1010) || (sec_cmd_i == 4'b1011));

  // R9
  pri_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pri_accept_o, pri_retry_o, pri_ignore_o}));

  // R9
  sec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sec_accept_o, sec_ignore_o}));

  // R9
  pri_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pri_addr_valid_i) |-> !(pri_accept_o || pri_retry_o || pri_ignore_o));

  // R1
  sec_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sec_qual) |-> sec_accept_o);

  // R3
  busy_retry_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pri_qual) && $past(busy_o)) |-> (pri_retry_o && !pri_accept_o));

  // R2
  strap_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy_o == $past(busy_strap_i)));

  // R7
  busy_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pri_wdata_valid_i) && !$past(sec_wdata_valid_i)) |-> $stable(busy_o));
endmodule

bind cfg_access_gate cfg_access_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .busy_strap_i      (busy_strap_i),
  .pri_addr_valid_i  (pri_addr_valid_i),
  .pri_cmd_i         (pri_cmd_i),
  .pri_addr_i        (pri_addr_i),
  .pri_idsel_i       (pri_idsel_i),
  .pri_wdata_valid_i (pri_wdata_valid_i),
  .sec_addr_valid_i  (sec_addr_valid_i),
  .sec_cmd_i         (sec_cmd_i),
  .sec_addr_i        (sec_addr_i),
  .sec_idsel_i       (sec_idsel_i),
  .sec_wdata_valid_i (sec_wdata_valid_i),
  .pri_accept_o      (pri_accept_o),
  .pri_retry_o       (pri_retry_o),
  .pri_ignore_o      (pri_ignore_o),
  .sec_accept_o      (sec_accept_o),
  .sec_ignore_o      (sec_ignore_o),
  .busy_o            (busy_o)
);

// File: tb/cfg_access_gate_bench.sv
module cfg_access_gate_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam logic [3:0] RD  = 4'b1010;
  localparam logic [3:0] WR  = 4'b1011;
  localparam logic [3:0] MEM = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_strap_i = 1'b0;
  logic pri_addr_valid_i = 1'b0, sec_addr_valid_i = 1'b0;
  logic [3:0] pri_cmd_i = '0, sec_cmd_i = '0;
  logic [ADDR_W-1:0] pri_addr_i = '0, sec_addr_i = '0;
  logic pri_idsel_i = 1'b0, sec_idsel_i = 1'b0;
  logic pri_wdata_valid_i = 1'b0, sec_wdata_valid_i = 1'b0;
  logic [DATA_W-1:0] pri_wdata_i = '0, sec_wdata_i = '0;
  logic [BE_W-1:0] pri_wbe_i = '0, sec_wbe_i = '0;
  logic pri_accept_o, pri_retry_o, pri_ignore_o;
  logic sec_accept_o, sec_ignore_o, busy_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] got;

  always #5 clk = ~clk;

  cfg_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg_access_gate (.*);

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap, input logic sidsel);
    @(negedge clk);
    rst = 1'b1;
    busy_strap_i = strap;
    sec_idsel_i = sidsel;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // address phase on one side; got = {accept, retry, ignore} one clock later
  task automatic addr_phase(input bit pri, input logic [3:0] cmd, input logic [7:0] addr,
                            input logic sel);
    @(negedge clk);
    if (pri) begin
      pri_addr_valid_i = 1'b1; pri_cmd_i = cmd; pri_addr_i = addr; pri_idsel_i = sel;
    end else begin
      sec_addr_valid_i = 1'b1; sec_cmd_i = cmd; sec_addr_i = addr; sec_idsel_i = sel;
    end
    @(negedge clk);
    got = pri ? {pri_accept_o, pri_retry_o, pri_ignore_o}
              : {sec_accept_o, 1'b0, sec_ignore_o};
    pri_addr_valid_i = 1'b0;
    sec_addr_valid_i = 1'b0;
    pri_idsel_i = 1'b0;
  endtask

  task automatic data_phase(input bit pri, input bit sec, input logic [DATA_W-1:0] pd,
                            input logic [DATA_W-1:0] sd, input logic [BE_W-1:0] be);
    @(negedge clk);
    pri_wdata_valid_i = pri; pri_wdata_i = pd; pri_wbe_i = be;
    sec_wdata_valid_i = sec; sec_wdata_i = sd; sec_wbe_i = be;
    @(negedge clk);
    pri_wdata_valid_i = 1'b0;
    sec_wdata_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b1);
    check("R2 busy after strap high", {2'b00, busy_o}, 3'b001);
    check("R2 pri outputs idle", {pri_accept_o, pri_retry_o, pri_ignore_o}, 3'b000);
    check("R2 sec outputs idle", {sec_accept_o, 1'b0, sec_ignore_o}, 3'b000);
    do_reset(1'b0, 1'b1);
    check("R2 busy after strap low", {2'b00, busy_o}, 3'b000);
  endtask

  task automatic t_sec_decode;
    do_reset(1'b1, 1'b1);
    addr_phase(0, RD, 8'h44, 1'b1); check("R1 sec cfg read", got, 3'b100);
    addr_phase(0, WR, 8'h08, 1'b1); check("R1 sec cfg write", got, 3'b100);
    addr_phase(0, MEM, 8'h44, 1'b1); check("R1 sec memory cmd", got, 3'b001);
    addr_phase(0, RD, 8'h45, 1'b1); check("R1 sec addr 01", got, 3'b001);
    addr_phase(0, RD, 8'h46, 1'b1); check("R1 sec addr 10", got, 3'b001);
    addr_phase(0, RD, 8'h44, 1'b0); check("R1 sec no select", got, 3'b001);
    @(negedge clk);
    check("R9 idle after phase", {sec_accept_o, 1'b0, sec_ignore_o}, 3'b000);
  endtask

  task automatic t_pri_busy;
    do_reset(1'b1, 1'b1);
    addr_phase(1, RD, 8'h00, 1'b1); check("R3 pri read retried", got, 3'b010);
    addr_phase(1, WR, 8'h44, 1'b1); check("R3 pri write retried", got, 3'b010);
    data_phase(1, 0, 32'h0, 32'h0, 4'hF);
    check("R3 retried write no effect", {2'b00, busy_o}, 3'b001);
    addr_phase(1, RD, 8'h01, 1'b1); check("R5 pri bad addr busy", got, 3'b001);
    addr_phase(1, MEM, 8'h00, 1'b1); check("R5 pri memory busy", got, 3'b001);
    @(negedge clk);
    check("R9 pri idle", {pri_accept_o, pri_retry_o, pri_ignore_o}, 3'b000);
  endtask

  task automatic t_sec_clear;
    do_reset(1'b1, 1'b1);
    addr_phase(0, WR, 8'h44, 1'b1); check("R6 sec write accepted", got, 3'b100);
    data_phase(0, 1, 32'h0, 32'hFFFF_FFFB, 4'h1);
    check("R6 busy cleared", {2'b00, busy_o}, 3'b000);
    addr_phase(1, RD, 8'h44, 1'b1); check("R4 pri accepted", got, 3'b100);
    addr_phase(1, RD, 8'h44, 1'b0); check("R5 pri no select", got, 3'b001);
  endtask

  task automatic t_no_effect;
    do_reset(1'b1, 1'b1);
    addr_phase(0, WR, 8'h44, 1'b1);
    data_phase(0, 1, 32'h0, 32'h0, 4'hE);
    check("R7 lane 0 disabled", {2'b00, busy_o}, 3'b001);
    addr_phase(0, WR, 8'h48, 1'b1);
    data_phase(0, 1, 32'h0, 32'h0, 4'hF);
    check("R7 other register", {2'b00, busy_o}, 3'b001);
    addr_phase(0, RD, 8'h44, 1'b1);
    data_phase(0, 1, 32'h0, 32'h0, 4'hF);
    check("R7 after read", {2'b00, busy_o}, 3'b001);
    data_phase(0, 1, 32'h0, 32'h0, 4'hF);
    check("R12 stray data phase", {2'b00, busy_o}, 3'b001);
    addr_phase(0, WR, 8'h44, 1'b1);
    data_phase(0, 1, 32'h0, 32'h0, 4'h0);
    data_phase(0, 1, 32'h0, 32'h0, 4'hF);
    check("R12 write consumed once", {2'b00, busy_o}, 3'b001);
  endtask

  task automatic t_pri_rewrite;
    do_reset(1'b0, 1'b1);
    addr_phase(1, WR, 8'h44, 1'b1); check("R4 pri write accepted", got, 3'b100);
    data_phase(1, 0, 32'h0000_0004, 32'h0, 4'h1);
    check("R8 pri sets busy", {2'b00, busy_o}, 3'b001);
    addr_phase(1, RD, 8'h44, 1'b1); check("R3 retry after set", got, 3'b010);
  endtask

  task automatic t_strap_low;
    do_reset(1'b0, 1'b0);
    addr_phase(0, RD, 8'h44, 1'b0); check("R10 sec ignored", got, 3'b001);
    addr_phase(1, RD, 8'h44, 1'b1); check("R10 pri not retried", got, 3'b100);
    addr_phase(1, WR, 8'h10, 1'b1); check("R10 pri write accepted", got, 3'b100);
  endtask

  task automatic t_both;
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    pri_addr_valid_i = 1'b1; pri_cmd_i = WR; pri_addr_i = 8'h44; pri_idsel_i = 1'b1;
    sec_addr_valid_i = 1'b1; sec_cmd_i = WR; sec_addr_i = 8'h44;
    @(negedge clk);
    check("R11 both accepted", {pri_accept_o, sec_accept_o, 1'b0}, 3'b110);
    pri_addr_valid_i = 1'b0; sec_addr_valid_i = 1'b0; pri_idsel_i = 1'b0;
    data_phase(1, 1, 32'h0000_0004, 32'h0, 4'h1);
    check("R11 secondary wins", {2'b00, busy_o}, 3'b000);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sec_decode();
    t_pri_busy();
    t_sec_clear();
    t_no_effect();
    t_pri_rewrite();
    t_strap_low();
    t_both();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule